// File: doc/BRIEF.md
# Register Image Burst Loader

This block walks a register-initialisation image held in a configuration EEPROM and turns it into 32-bit writes on a parallel register bus. It starts after the strap bytes have been loaded. It reads the image one byte at a time through a request/response port addressed by byte offset. A read request stays up, with a stable address, until the reader answers it.

The image begins at byte offset 12 with a validity byte. When that byte is 0xA5, the next byte gives the number of bursts. Each burst then carries a word-address byte, a word-count byte and four data bytes per word. The data bytes of each word arrive most significant first. Each assembled word goes out as one write strobe, and the address steps by one word after every write. If the validity byte holds any other value, the loader finishes at once and writes nothing. A run ends with a single-cycle done pulse and a status-clear pulse. An interrupt pulse comes out in the same cycle when the interrupt enable is high.

Top module: `regimg_loader`

## Requirements
- R1: A start pulse while idle makes the first read request use byte offset 12, the validity byte.
- R2: If the validity byte is not 0xA5, the loader makes no further reads, issues no writes and proceeds directly to its finishing cycle.
- R3: The byte at offset 13 is the burst count. A count of zero ends the run after two bytes have been read, with no writes.
- R4: Each burst starts with two header bytes. The first is word-address bits [9:2] and the second is the word count. The bus byte address is {word address, 2'b00}.
- R5: Every four data bytes form one word. The first byte lands in bits [31:24], then [23:16], then [15:8], and the last in [7:0].
- R6: Within a burst, each write's byte address is 4 above the previous one. The 8-bit word address wraps from 0x3FC to 0x000.
- R7: A burst whose word count is zero produces no writes, and the next header (or the finish) follows directly.
- R8: Only one read request is outstanding at a time. Its address holds until a response arrives. The byte offset rises by one per accepted response. A response that arrives with no request pending changes nothing.
- R9: The write strobe is high for exactly one cycle per word, in the cycle after the fourth byte of that word is accepted.
- R10: After the last item, done and status-clear are each high for exactly one cycle. The interrupt is high in that same cycle only when the interrupt enable is high.
- R11: A start pulse while a run is in progress has no effect on the reads or writes of that run.
- R12: Synchronous active-high reset returns the loader to idle with every output low, and a later start runs a full image normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (taken only while idle) |
| irq_en_i | input | 1 | Allow the interrupt pulse at the end of a run |
| rd_req_o | output | 1 | Byte read request, held until answered |
| rd_addr_o | output | EE_AW | EEPROM byte offset being requested |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 8 | Read response byte |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 10 | Register byte address |
| wr_data_o | output | 32 | Register write data |
| done_o | output | 1 | Run finished pulse |
| stat_clr_o | output | 1 | Pulse clearing the loader-active status |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest cases to reach are the boundary cases inside the byte stream. These are a zero word count in the first and last burst, an address that wraps inside a burst, and a start or a stray response that lands mid-run. The bench builds images arithmetically and places those cases at known offsets. Its EEPROM model answers with latencies from zero to three cycles. The model can also inject a response while no request is pending, and the bench fires start and reset in the middle of a long burst. For every image it predicts the exact offsets to be read, the write list and the cycle of each strobe.

// File: rtl/regimg_pkg.sv
package regimg_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int WADDR_W    = 8;
    localparam int LANE_SH    = $clog2(WORD_BYTES);
    localparam int BUS_AW     = WADDR_W + LANE_SH;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAG,
        ST_COUNT,
        ST_HADDR,
        ST_HLEN,
        ST_DATA,
        ST_FIN
    } ld_state_e;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [BYTE_W-1:0]  left;
    } burst_ctx_t;

    function automatic logic [BUS_AW-1:0] word_to_byte_addr(input logic [WADDR_W-1:0] w);
        return {w, {LANE_SH{1'b0}}};
    endfunction

    function automatic logic is_fetch_state(input ld_state_e s);
        return (s == ST_FLAG) || (s == ST_COUNT) || (s == ST_HADDR) ||
               (s == ST_HLEN) || (s == ST_DATA);
    endfunction
endpackage

// File: rtl/regimg_fetch.sv
module regimg_fetch #(
    parameter int AW    = 12,
    parameter int START = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seek_i,
    input  logic          get_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [7:0]    rd_data_i,
    output logic          byte_vld_o,
    output logic [7:0]    byte_o
);
    logic          pend_q;
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ptr_q  <= '0;
        end else if (seek_i) begin
            pend_q <= 1'b0;
            ptr_q  <= AW'(START);
        end else if (pend_q && rd_ack_i) begin
            pend_q <= 1'b0;
            ptr_q  <= ptr_q + 1'b1;
        end else if (get_i && !pend_q) begin
            pend_q <= 1'b1;
        end
    end

    assign rd_req_o   = pend_q;
    assign rd_addr_o  = ptr_q;
    assign byte_vld_o = pend_q && rd_ack_i;
    assign byte_o     = rd_data_i;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_ack_i) |=> (!rd_req_o && rd_addr_o == $past(rd_addr_o) + 1'b1)); // R8
endmodule

// File: rtl/regimg_pack.sv
module regimg_pack
    import regimg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int HELD_W = BYTE_W * (WORD_BYTES - 1);
    localparam int LW     = $clog2(WORD_BYTES);

    logic [HELD_W-1:0] held_q;
    logic [LW-1:0]     lane_q;
    logic              last_lane;

    assign last_lane  = (lane_q == LW'(WORD_BYTES - 1));
    assign word_vld_o = vld_i && last_lane;
    assign word_o     = {held_q, byte_i};

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            lane_q <= '0;
            held_q <= '0;
        end else if (vld_i) begin
            lane_q <= last_lane ? '0 : lane_q + 1'b1;
            held_q <= {held_q[HELD_W-BYTE_W-1:0], byte_i};
        end
    end
endmodule

// File: rtl/regimg_ctrl.sv
module regimg_ctrl
    import regimg_pkg::*;
#(
    parameter logic [7:0] FLAG_VAL = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              irq_en_i,
    input  logic              pend_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              seek_o,
    output logic              get_o,
    output logic              pack_vld_o,
    output logic              pack_clr_o,
    output logic              wr_en_o,
    output logic [BUS_AW-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              stat_clr_o,
    output logic              irq_o,
    output ld_state_e         st_o
);
    ld_state_e         state_q;
    logic [BYTE_W-1:0] bursts_q;
    burst_ctx_t        ctx_q;

    assign seek_o     = (state_q == ST_IDLE) && start_i;
    assign pack_clr_o = seek_o;
    assign get_o      = is_fetch_state(state_q) && !pend_i;
    assign pack_vld_o = byte_vld_i && (state_q == ST_DATA);
    assign done_o     = (state_q == ST_FIN);
    assign stat_clr_o = (state_q == ST_FIN);
    assign irq_o      = (state_q == ST_FIN) && irq_en_i;
    assign st_o       = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bursts_q  <= '0;
            ctx_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_FLAG;
                ST_FLAG: if (byte_vld_i)
                    state_q <= (byte_i == FLAG_VAL) ? ST_COUNT : ST_FIN;
                ST_COUNT: if (byte_vld_i) begin
                    bursts_q <= byte_i;
                    state_q  <= (byte_i == '0) ? ST_FIN : ST_HADDR;
                end
                ST_HADDR: if (byte_vld_i) begin
                    ctx_q.waddr <= byte_i;
                    state_q     <= ST_HLEN;
                end
                ST_HLEN: if (byte_vld_i) begin
                    ctx_q.left <= byte_i;
                    if (byte_i != '0) begin
                        state_q <= ST_DATA;
                    end else if (bursts_q <= 8'd1) begin
                        state_q <= ST_FIN;
                    end else begin
                        bursts_q <= bursts_q - 1'b1;
                        state_q  <= ST_HADDR;
                    end
                end
                ST_DATA: if (word_vld_i) begin
                    wr_en_o     <= 1'b1;
                    wr_addr_o   <= word_to_byte_addr(ctx_q.waddr);
                    wr_data_o   <= word_i;
                    ctx_q.waddr <= ctx_q.waddr + 1'b1;
                    ctx_q.left  <= ctx_q.left - 1'b1;
                    if (ctx_q.left == 8'd1) begin
                        if (bursts_q <= 8'd1) begin
                            state_q <= ST_FIN;
                        end else begin
                            bursts_q <= bursts_q - 1'b1;
                            state_q  <= ST_HADDR;
                        end
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o); // R9
    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> (state_q != ST_FLAG || $past(state_q) == ST_FLAG)); // R11
endmodule

// File: rtl/regimg_loader.sv
module regimg_loader
    import regimg_pkg::*;
#(
    parameter int         EE_AW    = 12,
    parameter int         FLAG_OFS = 12,
    parameter logic [7:0] FLAG_VAL = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              irq_en_i,
    output logic              rd_req_o,
    output logic [EE_AW-1:0]  rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              wr_en_o,
    output logic [BUS_AW-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              stat_clr_o,
    output logic              irq_o
);
    logic              seek, get, byte_vld, pack_vld, pack_clr, word_vld;
    logic [BYTE_W-1:0] byte_d;
    logic [WORD_W-1:0] word_d;
    ld_state_e         st;

    regimg_fetch #(.AW(EE_AW), .START(FLAG_OFS)) u_fetch (
        .clk(clk), .rst(rst), .seek_i(seek), .get_i(get),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .byte_vld_o(byte_vld), .byte_o(byte_d)
    );

    regimg_pack u_pack (
        .clk(clk), .rst(rst), .clr_i(pack_clr), .vld_i(pack_vld),
        .byte_i(byte_d), .word_vld_o(word_vld), .word_o(word_d)
    );

    regimg_ctrl #(.FLAG_VAL(FLAG_VAL)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .irq_en_i(irq_en_i),
        .pend_i(rd_req_o), .byte_vld_i(byte_vld), .byte_i(byte_d),
        .word_vld_i(word_vld), .word_i(word_d),
        .seek_o(seek), .get_o(get), .pack_vld_o(pack_vld), .pack_clr_o(pack_clr),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .done_o(done_o), .stat_clr_o(stat_clr_o), .irq_o(irq_o), .st_o(st)
    );

    AST_FLAG_FIRST: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLAG && rd_req_o) |-> (rd_addr_o == EE_AW'(FLAG_OFS))); // R1
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!rd_req_o && stat_clr_o)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
endmodule

// File: tb/regimg_loader_test.sv
module regimg_loader_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        irq_en = 1'b0;
    logic        rd_req;
    logic [11:0] rd_addr;
    logic        ack = 1'b0;
    logic [7:0]  rdata = 8'h00;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [31:0] wr_data;
    logic        done, sclr, irq;

    always #2.5 clk = ~clk;

    regimg_loader uut (
        .clk(clk), .rst(rst), .start_i(start), .irq_en_i(irq_en),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(ack), .rd_data_i(rdata),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .done_o(done), .stat_clr_o(sclr), .irq_o(irq)
    );

    int tests = 0;
    int fails = 0;

    logic [7:0]  mem [256];
    bit          is_last [256];
    logic [9:0]  exp_wa [64];
    logic [31:0] exp_wd [64];
    int n_exp = 0;
    int pos = 0;

    int lat = 0, wcnt = 0;
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, irq_cnt = 0, clr_cnt = 0;
    bit due_wr = 0, stray_req = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM model and output monitor, all on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            ack = 1'b0; wcnt = 0; due_wr = 0;
        end else begin
            if (wr_en) begin
                chk(due_wr, "R9 strobe cycle", 32'(wr_cnt), 32'(n_exp));
                if (wr_cnt < n_exp) begin
                    chk(wr_addr == exp_wa[wr_cnt], "R4/R6 address", 32'(wr_addr), 32'(exp_wa[wr_cnt]));
                    chk(wr_data == exp_wd[wr_cnt], "R5 data", wr_data, exp_wd[wr_cnt]);
                end else chk(1'b0, "R2/R7 extra write", 32'(wr_cnt), 32'(n_exp));
                wr_cnt++;
            end else if (due_wr) chk(1'b0, "R9 missing strobe", 32'(wr_cnt), 32'(n_exp));
            due_wr = 0;
            if (done) done_cnt++;
            if (irq)  irq_cnt++;
            if (sclr) clr_cnt++;
            if (ack) ack = 1'b0;
            else if (stray_req) begin
                ack = 1'b1; rdata = 8'h55; stray_req = 0;
            end else if (rd_req) begin
                if (wcnt >= lat) begin
                    chk(rd_addr == 12'(12 + rd_cnt), "R1/R8 read offset", 32'(rd_addr), 32'(12 + rd_cnt));
                    ack = 1'b1; rdata = mem[rd_addr[7:0]];
                    due_wr = is_last[rd_addr[7:0]];
                    rd_cnt++; wcnt = 0;
                end else wcnt++;
            end
        end
    end

    task automatic img_begin(input logic [7:0] flag, input logic [7:0] nb);
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 37 + 11); is_last[i] = 0; end
        mem[12] = flag; mem[13] = nb;
        pos = (flag == 8'hA5) ? 14 : 13;
        n_exp = 0;
    endtask

    task automatic add_burst(input logic [7:0] wa, input logic [7:0] cnt, input int seed);
        logic [31:0] w;
        mem[pos] = wa; mem[pos+1] = cnt; pos += 2;
        for (int i = 0; i < int'(cnt); i++) begin
            w = (32'(seed) * 32'h0101_0103) ^ (32'(i) * 32'h1357_9BDF) ^ 32'hC3A5_0F96;
            exp_wa[n_exp] = {8'(wa + 8'(i)), 2'b00};
            exp_wd[n_exp] = w;
            mem[pos] = w[31:24]; mem[pos+1] = w[23:16]; mem[pos+2] = w[15:8]; mem[pos+3] = w[7:0];
            is_last[pos+3] = 1;
            pos += 4; n_exp++;
        end
    endtask

    task automatic clear_mon();
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; irq_cnt = 0; clr_cnt = 0;
    endtask

    task automatic run_case(input int l, input bit ie, input bit midstart, input string req);
        int waited;
        clear_mon();
        lat = l; irq_en = ie;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (midstart) begin
            repeat (15) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 6000) begin @(negedge clk); waited++; end
        repeat (4) @(negedge clk);
        chk(wr_cnt == n_exp, req, 32'(wr_cnt), 32'(n_exp));
        chk(rd_cnt == pos - 12, "R8 bytes read", 32'(rd_cnt), 32'(pos - 12));
        chk(done_cnt == 1 && clr_cnt == 1, "R10 done/clear pulses", 32'(done_cnt), 32'(1));
        chk(irq_cnt == int'(ie), "R10 interrupt", 32'(irq_cnt), 32'(ie));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] a0;
        img_begin(8'hA5, 8'd0);
        repeat (3) @(negedge clk);
        chk(!rd_req && !wr_en && !done && !sclr && !irq, "R12 reset state", {wr_en, rd_req, done, sclr, irq}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: bad flag values
        foreach (mem[k]) if (k < 4) begin
            img_begin((k == 0) ? 8'h00 : (k == 1) ? 8'hA4 : (k == 2) ? 8'hFF : 8'h5A, 8'd3);
            run_case(k, k[0], 0, "R2 no writes on bad flag");
        end
        // R3: zero bursts
        img_begin(8'hA5, 8'd0);
        run_case(1, 1, 0, "R3 zero bursts");
        // R4 R5: single word
        img_begin(8'hA5, 8'd1); add_burst(8'h10, 8'd1, 1);
        run_case(0, 0, 0, "R4 single word");
        // R6 R7: mixed bursts with an empty one
        img_begin(8'hA5, 8'd3); add_burst(8'h20, 8'd3, 2); add_burst(8'h40, 8'd0, 3); add_burst(8'h05, 8'd2, 4);
        run_case(2, 1, 0, "R7 empty middle burst");
        // R6: wrap
        img_begin(8'hA5, 8'd1); add_burst(8'hFE, 8'd4, 5);
        run_case(3, 0, 0, "R6 address wrap");
        // R7: empty first and last bursts
        img_begin(8'hA5, 8'd2); add_burst(8'h30, 8'd0, 6); add_burst(8'h31, 8'd0, 7);
        run_case(1, 0, 0, "R7 all bursts empty");
        // sweep latency and count
        for (int l = 0; l < 4; l++)
            for (int c = 0; c < 5; c++) begin
                img_begin(8'hA5, 8'd2); add_burst(8'(l * 16 + c), 8'(c), l * 5 + c); add_burst(8'h80, 8'd1, 99);
                run_case(l, c[0], 0, "R5 sweep write count");
            end
        // R11: start while busy
        img_begin(8'hA5, 8'd2); add_burst(8'h50, 8'd3, 11); add_burst(8'h60, 8'd2, 12);
        run_case(1, 1, 1, "R11 start while busy");
        // R8: stray response while idle
        a0 = rd_addr;
        stray_req = 1;
        repeat (3) @(negedge clk);
        chk(!rd_req && rd_addr == a0 && !wr_en, "R8 stray response ignored", 32'(rd_addr), 32'(a0));
        run_case(0, 0, 0, "R8 run after stray response");
        // R12: reset in mid run
        clear_mon(); lat = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!rd_req && !wr_en && !done && !sclr && !irq, "R12 mid-run reset", {wr_en, rd_req, done, sclr, irq}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_req && !wr_en && !done, "R12 idle after reset", {wr_en, rd_req, done}, 0);
        run_case(2, 1, 0, "R12 full run after reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule